// File: doc/BRIEF.md
# Command-Completion Interrupt Controller

This block sits on the host register port of a memory device. It holds one ready/busy status bit, captures command words written by the host, and starts an operation engine with a one-cycle pulse. When the engine reports completion, the status bit returns to ready. The bit also drives an interrupt pin. The pin's level polarity and its output enable come from a small configuration register.

The host can run operations in one of two ways, and both can be used on the same device. In the manual style, software first clears the status bit by writing a zero to it, and then writes the command. In the automatic style, software writes a command while the bit still shows ready, and that write clears the bit by itself. A small operation stub with a programmable latency stands in for the engine in simulation.

Register map (word addresses, defaults): command register 0xF220, configuration register 0xF221, interrupt status register 0xF241. The status flag is bit 15 of the interrupt status register. In the configuration register, bit 0 is the pin output enable and bit 1 is the pin polarity.

Top module: `cmd_irq_ctrl`

## Requirements
- R1: After reset the status bit is 1 (ready), the output enable and the polarity are both 1, the pin level is 1, the pin is enabled and `op_start` is 0.
- R2: A write to the command address clears the status bit at that clock edge, including when the bit was 1 (automatic style).
- R3: Every command write raises `op_start` for exactly the one cycle after the write, and `op_cmd` then holds the written word. This happens whether the status bit was already 0 or was cleared by that write.
- R4: A write to the interrupt status address with bit 15 = 0 clears the status bit at that edge.
- R5: A write to the interrupt status address with bit 15 = 1 has no effect on the status bit, and neither does a write to any unmapped address.
- R6: An `op_done` pulse sets the status bit at the next edge. Nothing else can set it.
- R7: When `op_done` and a clearing write fall in the same cycle, the status bit becomes 1.
- R8: The pin level equals the status bit when the polarity (configuration bit 1) is 1, and equals its inverse when the polarity is 0.
- R9: `pin_oe` equals configuration bit 0. When `pin_oe` is 0 the pad is high-impedance, while `pin_level` keeps following R8.
- R10: With the stub at latency L (L ≥ 1, and 0 treated as 1), `op_done` comes L cycles after `op_start`. The status bit is therefore 0 for exactly L+1 cycles after the command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host write address |
| wr_data | input | 16 | Host write data |
| op_done | input | 1 | Completion pulse from the operation engine |
| op_start | output | 1 | One-cycle start pulse to the operation engine |
| op_cmd | output | 16 | Last captured command word |
| irq_bit | output | 1 | Status bit (1 = ready, 0 = busy) |
| pin_level | output | 1 | Interrupt pin level after the polarity is applied |
| pin_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its default 16-bit address and data widths and the default register addresses. The stub uses a 4-bit latency field. Because the configuration is this small, the bench can sweep every combination of output enable, polarity and clear style against stub latencies of 1, 2, 3 and 6. The ready-to-busy span and the pin level are predicted arithmetically for each case. Directed cases cover the remaining corners: a completion that lands on a clearing write, writes that set bit 15, and writes to unmapped addresses.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int CIC_AW        = 16;
  localparam int CIC_DW        = 16;
  localparam int CIC_A_CMD     = 'hF220;
  localparam int CIC_A_CFG     = 'hF221;
  localparam int CIC_A_IRQ     = 'hF241;
  localparam int CIC_IRQ_POS   = 15;
  localparam int CIC_CFG_OE    = 0;
  localparam int CIC_CFG_POL   = 1;

  typedef struct packed {
    logic pol;
    logic oe;
  } cic_cfg_t;
endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cic_decode.sv
module cic_decode #(
  parameter int             AW    = 16,
  parameter logic [AW-1:0]  A_CMD = '0,
  parameter logic [AW-1:0]  A_CFG = '0,
  parameter logic [AW-1:0]  A_IRQ = '0
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          cmd_wr,
  output logic          cfg_wr,
  output logic          irq_wr
);
  always_comb begin
    cmd_wr = wr_en && (wr_addr == A_CMD);
    cfg_wr = wr_en && (wr_addr == A_CFG);
    irq_wr = wr_en && (wr_addr == A_IRQ);
  end
endmodule

// File: rtl/cic_status.sv
module cic_status #(
  parameter int DW      = 16,
  parameter int IRQ_POS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          irq_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          op_done,
  output logic          irq_q,
  output logic          start_q,
  output logic [DW-1:0] cmd_q
);
  logic irq_d;
  logic clr_req;

  // Clearing requests: any command write, or a zero written to the flag.
  // Completion has priority over both.
  always_comb begin
    clr_req = cmd_wr || (irq_wr && !wr_data[IRQ_POS]);
    irq_d   = irq_q;
    if (clr_req) irq_d = 1'b0;
    if (op_done) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b1;
      start_q <= 1'b0;
    end else begin
      irq_q   <= irq_d;
      start_q <= cmd_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_wr) cmd_q <= wr_data;
  end
endmodule

// File: rtl/cic_pin.sv
module cic_pin
  import cic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_wr,
  input  cic_cfg_t cfg_in,
  input  logic     irq,
  output logic     pin_level,
  output logic     pin_oe
);
  cic_cfg_t cfg_q;
  cic_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '{pol: 1'b1, oe: 1'b1};
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    pin_level = cfg_q.pol ? irq : ~irq;
    pin_oe    = cfg_q.oe;
  end
endmodule

// File: rtl/cic_op_stub.sv
module cic_op_stub #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  output logic             done
);
  logic             busy_q, busy_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [LAT_W-1:0] eff_lat;

  always_comb begin
    eff_lat = (lat == '0) ? LAT_W'(1) : lat;
    done    = busy_q && (cnt_q == LAT_W'(1));
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = eff_lat;
    end else if (busy_q) begin
      cnt_d = cnt_q - LAT_W'(1);
      if (cnt_q == LAT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/cmd_irq_ctrl.sv
module cmd_irq_ctrl
  import cic_pkg::*;
#(
  parameter int            AW      = CIC_AW,
  parameter int            DW      = CIC_DW,
  parameter logic [AW-1:0] A_CMD   = AW'(CIC_A_CMD),
  parameter logic [AW-1:0] A_CFG   = AW'(CIC_A_CFG),
  parameter logic [AW-1:0] A_IRQ   = AW'(CIC_A_IRQ),
  parameter int            IRQ_POS = CIC_IRQ_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          op_done,
  output logic          op_start,
  output logic [DW-1:0] op_cmd,
  output logic          irq_bit,
  output logic          pin_level,
  output logic          pin_oe
);
  logic     rst_sync_n;
  logic     cmd_wr, cfg_wr, irq_wr;
  cic_cfg_t cfg_in;

  cic_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cic_decode #(.AW(AW), .A_CMD(A_CMD), .A_CFG(A_CFG), .A_IRQ(A_IRQ)) dec_i (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd_wr  (cmd_wr),
    .cfg_wr  (cfg_wr),
    .irq_wr  (irq_wr)
  );

  cic_status #(.DW(DW), .IRQ_POS(IRQ_POS)) stat_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_wr  (cmd_wr),
    .irq_wr  (irq_wr),
    .wr_data (wr_data),
    .op_done (op_done),
    .irq_q   (irq_bit),
    .start_q (op_start),
    .cmd_q   (op_cmd)
  );

  assign cfg_in = '{pol: wr_data[CIC_CFG_POL], oe: wr_data[CIC_CFG_OE]};

  cic_pin pin_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_wr    (cfg_wr),
    .cfg_in    (cfg_in),
    .irq       (irq_bit),
    .pin_level (pin_level),
    .pin_oe    (pin_oe)
  );
endmodule

// File: rtl/cic_chk.sv
module cic_chk
  import cic_pkg::*;
#(
  parameter int AW = CIC_AW,
  parameter int DW = CIC_DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          op_done,
  input logic          op_start,
  input logic [DW-1:0] op_cmd,
  input logic          irq_bit
);
  logic is_cmd, is_clr;
  assign is_cmd = wr_en && (wr_addr == AW'(CIC_A_CMD));
  assign is_clr = wr_en && (wr_addr == AW'(CIC_A_IRQ)) && !wr_data[CIC_IRQ_POS];

  // R2
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && !op_done) |=> !irq_bit);

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |=> (op_start && op_cmd == $past(wr_data)));

  // R3
  start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(is_cmd));

  // R4
  manual_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_clr && !op_done) |=> !irq_bit);

  // R5
  no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done && !is_cmd && !is_clr) |=> $stable(irq_bit));

  // R6
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> irq_bit);

  // R6
  rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_bit) |-> $past(op_done));
endmodule

bind cmd_irq_ctrl cic_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .op_done  (op_done),
  .op_start (op_start),
  .op_cmd   (op_cmd),
  .irq_bit  (irq_bit)
);

// File: tb/cmd_irq_ctrl_tb_top.sv
module cmd_irq_ctrl_tb_top;
  localparam logic [15:0] ADR_CMD = 16'hF220;
  localparam logic [15:0] ADR_CFG = 16'hF221;
  localparam logic [15:0] ADR_IRQ = 16'hF241;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr, wr_data;
  logic        op_done, op_start, irq_bit, pin_level, pin_oe;
  logic [15:0] op_cmd;
  logic [3:0]  lat;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  cmd_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .op_start(op_start),
    .op_cmd(op_cmd), .irq_bit(irq_bit), .pin_level(pin_level), .pin_oe(pin_oe)
  );

  cic_op_stub #(.LAT_W(4)) stub_i (
    .clk(clk), .rst_n(rst_n), .start(op_start), .lat(lat), .done(op_done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_pin(input string req, input int pol, input int oe, input int irq_exp);
    check({req, " pin level"}, int'(pin_level), pol ? irq_exp : 1 - irq_exp);
    check({req, " pin oe"}, int'(pin_oe), oe);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lats[4] = '{1, 2, 3, 6};
    int idx = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; lat = 4'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", int'(irq_bit), 1);
    check("R1 start", int'(op_start), 0);
    check_pin("R1", 1, 1, 1);

    for (int oe = 0; oe < 2; oe++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int man = 0; man < 2; man++) begin
          for (int li = 0; li < 4; li++) begin
            int k;
            logic [15:0] cv;
            lat = 4'(lats[li]);
            wr(ADR_CFG, 16'(pol * 2 + oe));
            check("R5 ready before", int'(irq_bit), 1);
            check_pin("R8 R9 ready", pol, oe, 1);
            if (man != 0) begin
              wr(ADR_IRQ, 16'h7FFF);
              check("R4 manual clear", int'(irq_bit), 0);
              check_pin("R8 R9 manual", pol, oe, 0);
              @(negedge clk);
              check("R4 stays clear", int'(irq_bit), 0);
              check("R3 no start on clear", int'(op_start), 0);
            end
            cv = 16'h0100 + 16'(idx);
            idx++;
            wr(ADR_CMD, cv);
            check("R3 start high", int'(op_start), 1);
            check("R3 cmd captured", int'(op_cmd), int'(cv));
            check(man ? "R3 busy manual" : "R2 auto clear", int'(irq_bit), 0);
            check_pin("R8 R9 busy", pol, oe, 0);
            @(negedge clk);
            check("R3 start one cycle", int'(op_start), 0);
            k = 1;
            while (!irq_bit && k < 40) begin
              @(negedge clk);
              k++;
            end
            check("R10 busy span", k, lats[li] + 1);
            check_pin("R8 R9 done", pol, oe, 1);
          end
        end
      end
    end

    // R5: writes with flag bit 1 and unmapped writes are ignored
    wr(ADR_CFG, 16'h0003);
    lat = 4'd6;
    wr(ADR_CMD, 16'hBEEF);
    wr(ADR_IRQ, 16'h8000);
    check("R5 set write ignored busy", int'(irq_bit), 0);
    wr(16'h1234, 16'h0000);
    check("R5 unmapped ignored busy", int'(irq_bit), 0);
    while (!irq_bit) @(negedge clk);
    wr(ADR_IRQ, 16'hFFFF);
    check("R5 set write ignored ready", int'(irq_bit), 1);
    wr(16'hF240, 16'h0000);
    check("R5 unmapped ignored ready", int'(irq_bit), 1);
    check_pin("R5 R8", 1, 1, 1);

    // R7: completion coincides with a clearing write
    lat = 4'd3;
    wr(ADR_CMD, 16'h00C3);
    while (!op_done) @(negedge clk);
    wr_en = 1'b1; wr_addr = ADR_IRQ; wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 done wins", int'(irq_bit), 1);
    @(negedge clk);
    check("R7 stays ready", int'(irq_bit), 1);

    // R10 latency zero treated as one
    lat = 4'd0;
    wr(ADR_CMD, 16'h0042);
    begin
      int k = 0;
      while (!irq_bit && k < 40) begin
        @(negedge clk);
        k++;
      end
      check("R10 zero latency span", k, 2);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule